// File: doc/BRIEF.md
# Ready and Burst Credit Counter

This block keeps track of the flow-control credit a remote receiver grants to a sending channel. Each single-cycle grant pulse from the receiver adds one to a ready counter. Each completed burst adds one to a burst counter. When the two counters differ, at least one grant has not yet been answered by a burst, and the block raises a permit output that lets the sender start its next burst. When they are equal, the permit stays low and the sender must wait.

The ready counter must not wrap around. Whenever the burst counter advances, its old value is copied into a history register. A grant that would move the ready counter onto that saved value is dropped. This caps the unanswered grants at one less than the counter range. Dropped grants are not queued; counting picks up again only after the history register takes a new value. A synchronous connection clear and an asynchronous active-low reset both return all three registers to zero.

Top module: `burst_credit_tracker`

## Requirements
- R1: After the asynchronous reset, or in the cycle after `conn_clr` is sampled high, `ready_count`, `burst_count` and `last_burst` are all zero and `permit` is low.
- R2: A sampled `ready_pulse` that is not blocked by R6 raises `ready_count` by one at the next clock edge.
- R3: A sampled `burst_done` raises `burst_count` by one at the next clock edge, modulo 2^16 (0xFFFF goes to 0x0000).
- R4: At the edge where `burst_done` is taken, `last_burst` receives the value `burst_count` held before that edge.
- R5: `permit` is high exactly when `ready_count` and `burst_count` differ. It follows updated counter values in the cycle after the pulses that caused them.
- R6: A `ready_pulse` is dropped, and `ready_count` is left unchanged, when `ready_count + 1` (mod 2^16) equals `last_burst`. From reset with no bursts, `ready_count` therefore stops at 0xFFFF.
- R7: Dropped grants are not remembered. `ready_count` moves only on a sampled, unblocked `ready_pulse`, and it resumes counting from its held value once `last_burst` changes.
- R8: When `ready_pulse` and `burst_done` are sampled in the same cycle, both counters update at the same edge.
- R9: `conn_clr` takes priority over `ready_pulse` and `burst_done` sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conn_clr | input | 1 | Synchronous connection clear of all counters |
| ready_pulse | input | 1 | One-cycle grant from the remote receiver |
| burst_done | input | 1 | One-cycle marker that a burst reached its last word |
| permit | output | 1 | High while unanswered grants exist |
| ready_count | output | 16 | Ready counter value |
| burst_count | output | 16 | Burst counter value |
| last_burst | output | 16 | Burst count saved before the latest burst |

## Verification
The hardest state to reach is the saturation limit: about 65,535 grants must arrive with no burst in between before the drop rule takes effect. Random traffic never gets there. A directed phase therefore sends 65,540 back-to-back grants after a clear and checks that the counter holds at 0xFFFF. One burst follows, and the bench checks that the counter still holds because the history register saved zero. A second burst moves the history register, and the bench checks that exactly one more grant is accepted before the new cap takes hold.

// File: rtl/credit_pkg.sv
package credit_pkg;

  localparam int unsigned CREDIT_W = 16;

  typedef struct packed {
    logic clear;
    logic grant;
    logic done;
  } credit_evt_t;

endpackage

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;
  logic         count_en;

  always_comb begin
    count_en = clr | inc;
    if (clr) begin
      count_d = '0;
    end else begin
      count_d = count_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/history_reg.sv
module history_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;
  logic         hist_en;

  always_comb begin
    hist_en = clr | load;
    hist_d  = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (hist_en) begin
      hist_q <= hist_d;
    end
  end

  assign dout = hist_q;

endmodule

// File: rtl/grant_limiter.sv
module grant_limiter #(
  parameter int unsigned W = 16
) (
  input  logic         grant,
  input  logic [W-1:0] ready_now,
  input  logic [W-1:0] hist_now,
  output logic         grant_ok
);

  logic [W-1:0] ready_plus1;
  logic         at_cap;

  always_comb begin
    ready_plus1 = ready_now + W'(1);
    at_cap      = (ready_plus1 == hist_now);
    grant_ok    = grant & ~at_cap;
  end

endmodule

// File: rtl/burst_credit_tracker.sv
module burst_credit_tracker
  import credit_pkg::*;
#(
  parameter int unsigned W = CREDIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conn_clr,
  input  logic         ready_pulse,
  input  logic         burst_done,
  output logic         permit,
  output logic [W-1:0] ready_count,
  output logic [W-1:0] burst_count,
  output logic [W-1:0] last_burst
);

  credit_evt_t  evt;
  logic         grant_ok;
  logic         ready_inc;
  logic         burst_inc;
  logic [W-1:0] ready_q;
  logic [W-1:0] burst_q;
  logic [W-1:0] hist_q;

  always_comb begin
    evt.clear = conn_clr;
    evt.grant = ready_pulse;
    evt.done  = burst_done;
  end

  grant_limiter #(.W(W)) u_limit (
    .grant     (evt.grant),
    .ready_now (ready_q),
    .hist_now  (hist_q),
    .grant_ok  (grant_ok)
  );

  always_comb begin
    ready_inc = grant_ok & ~evt.clear;
    burst_inc = evt.done & ~evt.clear;
  end

  credit_counter #(.W(W)) u_ready_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (evt.clear),
    .inc   (ready_inc),
    .count (ready_q)
  );

  credit_counter #(.W(W)) u_burst_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (evt.clear),
    .inc   (burst_inc),
    .count (burst_q)
  );

  history_reg #(.W(W)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (evt.clear),
    .load  (burst_inc),
    .din   (burst_q),
    .dout  (hist_q)
  );

  assign permit      = (ready_q != burst_q);
  assign ready_count = ready_q;
  assign burst_count = burst_q;
  assign last_burst  = hist_q;

endmodule

// File: rtl/credit_checker.sv
module credit_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conn_clr,
  input logic         ready_pulse,
  input logic         burst_done,
  input logic         permit,
  input logic [W-1:0] ready_count,
  input logic [W-1:0] burst_count,
  input logic [W-1:0] last_burst
);

  logic [W-1:0] ready_next;
  assign ready_next = ready_count + W'(1);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conn_clr |=> (ready_count == '0 && burst_count == '0 && last_burst == '0 && !permit));

  assert_ready_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_pulse && !conn_clr && ready_next != last_burst)
      |=> ready_count == $past(ready_count) + W'(1));

  assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !conn_clr) |=> burst_count == $past(burst_count) + W'(1));

  assert_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !conn_clr) |=> last_burst == $past(burst_count));

  assert_permit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_pulse && !burst_done && !conn_clr) |=> $stable(permit));

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_pulse && !conn_clr && ready_next == last_burst) |=> $stable(ready_count));

  assert_no_memory_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_pulse && !conn_clr) |=> $stable(ready_count));

endmodule

bind burst_credit_tracker credit_checker #(.W(W)) u_credit_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .conn_clr    (conn_clr),
  .ready_pulse (ready_pulse),
  .burst_done  (burst_done),
  .permit      (permit),
  .ready_count (ready_count),
  .burst_count (burst_count),
  .last_burst  (last_burst)
);

// File: tb/test_burst_credit_tracker.sv
module test_burst_credit_tracker;

  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         conn_clr;
  logic         ready_pulse;
  logic         burst_done;
  logic         permit;
  logic [W-1:0] ready_count;
  logic [W-1:0] burst_count;
  logic [W-1:0] last_burst;

  int n_chk;
  int n_fail;
  bit done_flag;

  logic [W-1:0] m_ready;
  logic [W-1:0] m_burst;
  logic [W-1:0] m_last;

  burst_credit_tracker #(.W(W)) i_burst_credit_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .conn_clr    (conn_clr),
    .ready_pulse (ready_pulse),
    .burst_done  (burst_done),
    .permit      (permit),
    .ready_count (ready_count),
    .burst_count (burst_count),
    .last_burst  (last_burst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] exp_ready(input logic [W-1:0] r, input logic [W-1:0] l,
                                             input logic g, input logic c);
    if (c) return '0;
    if (g && (r + W'(1)) != l) return r + W'(1);
    return r;
  endfunction

  function automatic logic exp_permit(input logic [W-1:0] r, input logic [W-1:0] b);
    return r != b;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "ready_count", int'(ready_count), int'(m_ready));
    check(tag, "burst_count", int'(burst_count), int'(m_burst));
    check(tag, "last_burst", int'(last_burst), int'(m_last));
    check(tag, "permit", int'(permit), int'(exp_permit(m_ready, m_burst)));
  endtask

  task automatic cyc(input logic g, input logic b, input logic c, input string tag, input bit full);
    @(negedge clk);
    ready_pulse = g;
    burst_done  = b;
    conn_clr    = c;
    @(posedge clk);
    #1;
    m_ready = exp_ready(m_ready, m_last, g, c);
    if (c) begin
      m_burst = '0;
      m_last  = '0;
    end else if (b) begin
      m_last  = m_burst;
      m_burst = m_burst + W'(1);
    end
    if (full) check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done_flag = 0;
    rst_n = 1'b0; conn_clr = 1'b0; ready_pulse = 1'b0; burst_done = 1'b0;
    m_ready = '0; m_burst = '0; m_last = '0;
    void'($urandom(32'h1f2e3d4c));
    #1;
    check_all("R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, "R1", 1);

    // R2 / R5 directed: single grant raises permit
    cyc(1'b1, 1'b0, 1'b0, "R2", 1);
    check("R5", "permit after grant", int'(permit), 1);
    // R3 / R4 directed: burst answers grant
    cyc(1'b0, 1'b1, 1'b0, "R3", 1);
    check("R4", "last_burst", int'(last_burst), 0);
    check("R5", "permit after answer", int'(permit), 0);
    // R8 simultaneous
    cyc(1'b1, 1'b1, 1'b0, "R8", 1);
    check("R8", "ready_count", int'(ready_count), 2);
    check("R8", "burst_count", int'(burst_count), 2);
    // R9 clear over pulses
    cyc(1'b1, 1'b1, 1'b1, "R9", 1);
    check("R9", "ready_count", int'(ready_count), 0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic g, b, c;
      g = ($urandom() % 3) != 0;
      b = ($urandom() % 3) == 0;
      c = ($urandom() % 200) == 0;
      cyc(g, b, c, "R5", 1);
    end

    // asynchronous reset mid-run
    cyc(1'b1, 1'b0, 1'b0, "R2", 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_ready = '0; m_burst = '0; m_last = '0;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // saturation: 65,540 grants with no burst
    for (int i = 0; i < 65540; i++) cyc(1'b1, 1'b0, 1'b0, "R6", 0);
    check("R6", "ready held at cap", int'(ready_count), 16'hFFFF);
    check_all("R6");
    cyc(1'b0, 1'b1, 1'b0, "R4", 1);
    check("R4", "last_burst after first burst", int'(last_burst), 0);
    cyc(1'b1, 1'b0, 1'b0, "R7", 1);
    check("R7", "still held", int'(ready_count), 16'hFFFF);
    cyc(1'b0, 1'b1, 1'b0, "R4", 1);
    check("R4", "last_burst after second burst", int'(last_burst), 1);
    cyc(1'b0, 1'b0, 1'b0, "R7", 1);
    check("R7", "no queued grant", int'(ready_count), 16'hFFFF);
    cyc(1'b1, 1'b0, 1'b0, "R7", 1);
    check("R7", "resumed and wrapped", int'(ready_count), 0);
    cyc(1'b1, 1'b0, 1'b0, "R6", 1);
    check("R6", "new cap", int'(ready_count), 0);
    check("R5", "permit with credit", int'(permit), 1);

    // R3 wrap of burst counter
    cyc(1'b0, 1'b0, 1'b1, "R1", 1);
    for (int i = 0; i < 65536; i++) cyc(1'b0, 1'b1, 1'b0, "R3", 0);
    check("R3", "burst wrap", int'(burst_count), 0);
    check("R4", "last before wrap", int'(last_burst), 16'hFFFF);
    check_all("R3");

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule